// File: doc/BRIEF.md
# Suspend and Resume Power Sequencer

This block carries a memory subsystem into deep sleep and back without any processor code running from the external memory. After a one-cycle `start` pulse it walks a fixed program of register updates over a single-outstanding memory-mapped master port. The program puts the DDR controller into self-refresh with its clock stopped, switches the DDR module off through the power/sleep controller and gates the PHY clock. It then bypasses and powers down the DDR PLL and finally raises the deep-sleep enable bit. The sequencer then parks until `wake` arrives. Resume runs the mirror path: it clears the sleep bit, resets, powers up and relocks the PLL, reopens the PHY clock, re-enables the module and lets the controller leave low-power mode.

Each register change is a read of the target followed by a write of the read value with only the program's bits altered. Settling times are counted in clock cycles. The PHY-ready delay is a plain cycle count. The PLL bypass, reset and lock delays are given in microseconds and multiplied by the bypass clock rate in MHz. The power controller's transition is handled by polling its status registers rather than by a fixed delay.

Top module: `sleep_seq`

## Requirements
- R1: After reset `busy`, `done` and `bus_valid` are all low, and `bus_valid` stays low whenever `busy` is low.
- R2: Every update reads the target and then, with no idle cycle between, writes the same address with the read value changed only in the program's bits. A request holds its address and direction until `bus_ready` is seen. Unless a timed wait intervenes, one idle cycle separates the completing write from the next request.
- R3: Entry starts with two separate writes to the refresh-control register at DDR_BASE+0x0C. The first clears bit 23 (self-refresh select) and sets bit 31 (low-power enable). The second sets bit 30 (clock-stop enable).
- R4: After the clock-stop write the bus is idle for exactly PHY_WAIT+2 cycles before the next request.
- R5: A module transition writes the state field [5:0] of the module-control register (PSC_BASE+0xA00+4*MOD_IDX) to 2 on entry and to 3 on resume. It then sets bit 0 of the command register (PSC_BASE+0x120). No later step starts until bit 0 of the status register (PSC_BASE+0x128) reads 0 and field [5:0] of the module-status register (PSC_BASE+0x800+4*MOD_IDX) reads the requested code.
- R6: Entry then clears bit 15 (divider enable) of divider 1 at PLL_BASE+0x118. Next, one write to the PLL control register at PLL_BASE+0x100 clears bit 5 (enable source) and bit 0 (PLL enable).
- R7: After the bypass wait the PLL control register gets bit 1 (power-down) set. The bus is idle for exactly BYPASS_US*CLK_MHZ+2 cycles before that access.
- R8: Entry ends by setting bit 31 of the register at SLEEP_ADDR. The sequencer then issues no request and keeps `busy` high until `wake`. A `wake` pulse at any other time has no effect on the sequence.
- R9: Resume runs these writes in order: clear sleep bit 31, clear PLL bit 3 (reset), clear PLL bit 1, set PLL bit 3, then one write that clears bit 5 and sets bit 0. The bus idles exactly RESET_US*CLK_MHZ+2 cycles before the reset release and LOCK_US*CLK_MHZ+2 cycles before the final PLL write.
- R10: Resume then sets divider bit 15 and re-enables the module per R5. It clears refresh-control bit 30 and finally, in a separate write, bit 31. The other bits of every register keep their values.
- R11: `done` is high for exactly one cycle, two cycles after the final write completes, and `busy` falls in that same cycle. `start` is ignored while `busy` is high.
- R12: Wait lengths follow the parameters: PHY_WAIT cycles, and each PLL wait is its microsecond parameter times CLK_MHZ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the suspend program (ignored while busy) |
| wake | input | 1 | Resume from deep sleep |
| busy | output | 1 | Sequence in progress, including the sleep phase |
| done | output | 1 | One-cycle pulse at the end of resume |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Target accepts the request this cycle; read data valid |
| bus_rdata | input | 32 | Read data, sampled when valid and ready are both high on a read |

## Verification
A wrong program counter or phase shows at the ports on the very next access: either the address leaves the expected order, or the written word differs from the read value in bits the program does not own. A miscounted wait shows as a wrong idle stretch before the following request, and it is measured to the cycle. A sequencer that skips the power-controller poll is caught because its next access is issued while the modelled module state has not yet reached the requested code. A sequencer that leaves the sleep phase early is caught because a request appears before `wake`.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_STEPS = 28;
    localparam int PC_W      = $clog2(NUM_STEPS);

    // register offsets from each target's base
    localparam logic [31:0] OFF_REFCTL = 32'h0000_000C;
    localparam logic [31:0] OFF_PTGO   = 32'h0000_0120;
    localparam logic [31:0] OFF_PTBUSY = 32'h0000_0128;
    localparam logic [31:0] OFF_MSTAT  = 32'h0000_0800;
    localparam logic [31:0] OFF_MCTL   = 32'h0000_0A00;
    localparam logic [31:0] OFF_PLLC   = 32'h0000_0100;
    localparam logic [31:0] OFF_DIV1   = 32'h0000_0118;

    // bit masks inside those registers
    localparam logic [31:0] M_SRSEL  = 32'h0080_0000;
    localparam logic [31:0] M_CKSTOP = 32'h4000_0000;
    localparam logic [31:0] M_LPEN   = 32'h8000_0000;
    localparam logic [31:0] M_STATE  = 32'h0000_003F;
    localparam logic [31:0] M_GO     = 32'h0000_0001;
    localparam logic [31:0] M_DIVEN  = 32'h0000_8000;
    localparam logic [31:0] M_PLLEN  = 32'h0000_0001;
    localparam logic [31:0] M_PWRDN  = 32'h0000_0002;
    localparam logic [31:0] M_PLLRST = 32'h0000_0008;
    localparam logic [31:0] M_ENSRC  = 32'h0000_0020;
    localparam logic [31:0] M_SLEEP  = 32'h8000_0000;

    typedef enum logic [2:0] {
        OP_RMW, OP_POLL, OP_WAIT, OP_SLEEP, OP_FINISH
    } op_e;

    typedef enum logic [1:0] {
        TS_PHY, TS_BYP, TS_RST, TS_LOCK
    } tsel_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_EXEC, PH_RD, PH_WR, PH_WAIT, PH_SLEEP
    } phase_e;

    // for OP_POLL: clr is the compare mask, set the expected value
    typedef struct packed {
        op_e         op;
        tsel_e       tsel;
        logic [31:0] clr;
        logic [31:0] set;
    } step_t;

    typedef struct packed {
        phase_e            ph;
        logic [PC_W-1:0]   pc;
        logic [REG_W-1:0]  data;
        logic              done;
    } seq_t;

    function automatic step_t mk(op_e op, tsel_e ts, logic [31:0] c, logic [31:0] s);
        step_t r;
        r.op   = op;
        r.tsel = ts;
        r.clr  = c;
        r.set  = s;
        return r;
    endfunction

endpackage

// File: rtl/sleep_seq_prog.sv
module sleep_seq_prog
    import sleep_seq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] DDR_BASE   = 'h1000,
    parameter logic [ADDR_W-1:0] PSC_BASE   = 'h2000,
    parameter logic [ADDR_W-1:0] PLL_BASE   = 'h3000,
    parameter logic [ADDR_W-1:0] SLEEP_ADDR = 'h4000,
    parameter int                MOD_IDX    = 6
) (
    input  logic [PC_W-1:0]   pc,
    output step_t             step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] A_REF  = DDR_BASE + ADDR_W'(OFF_REFCTL);
    localparam logic [ADDR_W-1:0] A_MCTL = PSC_BASE + ADDR_W'(OFF_MCTL + 32'(4 * MOD_IDX));
    localparam logic [ADDR_W-1:0] A_MST  = PSC_BASE + ADDR_W'(OFF_MSTAT + 32'(4 * MOD_IDX));
    localparam logic [ADDR_W-1:0] A_GO   = PSC_BASE + ADDR_W'(OFF_PTGO);
    localparam logic [ADDR_W-1:0] A_BSY  = PSC_BASE + ADDR_W'(OFF_PTBUSY);
    localparam logic [ADDR_W-1:0] A_PLLC = PLL_BASE + ADDR_W'(OFF_PLLC);
    localparam logic [ADDR_W-1:0] A_DIV1 = PLL_BASE + ADDR_W'(OFF_DIV1);

    always_comb begin
        addr = '0;
        step = mk(OP_FINISH, TS_PHY, '0, '0);
        unique case (pc)
            // ---- suspend path ----
            5'd0:  begin addr = A_REF;  step = mk(OP_RMW,  TS_PHY, M_SRSEL, M_LPEN);        end
            5'd1:  begin addr = A_REF;  step = mk(OP_RMW,  TS_PHY, '0, M_CKSTOP);           end
            5'd2:  begin                step = mk(OP_WAIT, TS_PHY, '0, '0);                 end
            5'd3:  begin addr = A_MCTL; step = mk(OP_RMW,  TS_PHY, M_STATE, 32'h2);         end
            5'd4:  begin addr = A_GO;   step = mk(OP_RMW,  TS_PHY, '0, M_GO);               end
            5'd5:  begin addr = A_BSY;  step = mk(OP_POLL, TS_PHY, M_GO, '0);               end
            5'd6:  begin addr = A_MST;  step = mk(OP_POLL, TS_PHY, M_STATE, 32'h2);         end
            5'd7:  begin addr = A_DIV1; step = mk(OP_RMW,  TS_PHY, M_DIVEN, '0);            end
            5'd8:  begin addr = A_PLLC; step = mk(OP_RMW,  TS_PHY, M_ENSRC | M_PLLEN, '0);  end
            5'd9:  begin                step = mk(OP_WAIT, TS_BYP, '0, '0);                 end
            5'd10: begin addr = A_PLLC; step = mk(OP_RMW,  TS_PHY, '0, M_PWRDN);            end
            5'd11: begin addr = SLEEP_ADDR; step = mk(OP_RMW, TS_PHY, '0, M_SLEEP);         end
            5'd12: begin                step = mk(OP_SLEEP, TS_PHY, '0, '0);                end
            // ---- resume path ----
            5'd13: begin addr = SLEEP_ADDR; step = mk(OP_RMW, TS_PHY, M_SLEEP, '0);         end
            5'd14: begin addr = A_PLLC; step = mk(OP_RMW,  TS_PHY, M_PLLRST, '0);           end
            5'd15: begin addr = A_PLLC; step = mk(OP_RMW,  TS_PHY, M_PWRDN, '0);            end
            5'd16: begin                step = mk(OP_WAIT, TS_RST, '0, '0);                 end
            5'd17: begin addr = A_PLLC; step = mk(OP_RMW,  TS_PHY, '0, M_PLLRST);           end
            5'd18: begin                step = mk(OP_WAIT, TS_LOCK, '0, '0);                end
            5'd19: begin addr = A_PLLC; step = mk(OP_RMW,  TS_PHY, M_ENSRC, M_PLLEN);       end
            5'd20: begin addr = A_DIV1; step = mk(OP_RMW,  TS_PHY, '0, M_DIVEN);            end
            5'd21: begin addr = A_MCTL; step = mk(OP_RMW,  TS_PHY, M_STATE, 32'h3);         end
            5'd22: begin addr = A_GO;   step = mk(OP_RMW,  TS_PHY, '0, M_GO);               end
            5'd23: begin addr = A_BSY;  step = mk(OP_POLL, TS_PHY, M_GO, '0);               end
            5'd24: begin addr = A_MST;  step = mk(OP_POLL, TS_PHY, M_STATE, 32'h3);         end
            5'd25: begin addr = A_REF;  step = mk(OP_RMW,  TS_PHY, M_CKSTOP, '0);           end
            5'd26: begin addr = A_REF;  step = mk(OP_RMW,  TS_PHY, M_LPEN, '0);             end
            default: begin              step = mk(OP_FINISH, TS_PHY, '0, '0);               end
        endcase
    end
endmodule

// File: rtl/sleep_seq_timer.sv
module sleep_seq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // last cycle of an N-cycle wait
    assign expired = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleep_seq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] DDR_BASE   = 'h1000,
    parameter logic [ADDR_W-1:0] PSC_BASE   = 'h2000,
    parameter logic [ADDR_W-1:0] PLL_BASE   = 'h3000,
    parameter logic [ADDR_W-1:0] SLEEP_ADDR = 'h4000,
    parameter int                MOD_IDX    = 6,
    parameter int                PHY_WAIT   = 4096,
    parameter int                CLK_MHZ    = 25,
    parameter int                BYPASS_US  = 4,
    parameter int                RESET_US   = 1,
    parameter int                LOCK_US    = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wake,
    output logic              busy,
    output logic              done,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_ready,
    input  logic [REG_W-1:0]  bus_rdata
);
    localparam int BYP_CYC  = BYPASS_US * CLK_MHZ;
    localparam int RST_CYC  = RESET_US * CLK_MHZ;
    localparam int LOCK_CYC = LOCK_US * CLK_MHZ;
    localparam int MAX_A    = (PHY_WAIT > BYP_CYC) ? PHY_WAIT : BYP_CYC;
    localparam int MAX_B    = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
    localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    seq_t              cur_d, cur_q;
    step_t             step;
    logic [ADDR_W-1:0] step_addr;
    logic              t_load, t_done;
    logic [CNT_W-1:0]  t_val;

    sleep_seq_prog #(
        .ADDR_W(ADDR_W), .DDR_BASE(DDR_BASE), .PSC_BASE(PSC_BASE),
        .PLL_BASE(PLL_BASE), .SLEEP_ADDR(SLEEP_ADDR), .MOD_IDX(MOD_IDX)
    ) u_prog (
        .pc   (cur_q.pc),
        .step (step),
        .addr (step_addr)
    );

    sleep_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    always_comb begin
        unique case (step.tsel)
            TS_PHY:  t_val = CNT_W'(PHY_WAIT);
            TS_BYP:  t_val = CNT_W'(BYP_CYC);
            TS_RST:  t_val = CNT_W'(RST_CYC);
            default: t_val = CNT_W'(LOCK_CYC);
        endcase
    end

    always_comb begin
        cur_d      = cur_q;
        cur_d.done = 1'b0;
        t_load     = 1'b0;
        unique case (cur_q.ph)
            PH_IDLE: begin
                if (start) begin
                    cur_d.ph = PH_EXEC;
                    cur_d.pc = '0;
                end
            end
            PH_EXEC: begin
                unique case (step.op)
                    OP_RMW, OP_POLL: cur_d.ph = PH_RD;
                    OP_WAIT: begin
                        t_load   = 1'b1;
                        cur_d.ph = PH_WAIT;
                    end
                    OP_SLEEP: cur_d.ph = PH_SLEEP;
                    default: begin
                        cur_d.ph   = PH_IDLE;
                        cur_d.done = 1'b1;
                    end
                endcase
            end
            PH_RD: begin
                if (bus_ready) begin
                    if (step.op == OP_POLL) begin
                        if ((bus_rdata & step.clr) == step.set) begin
                            cur_d.pc = cur_q.pc + 1'b1;
                            cur_d.ph = PH_EXEC;
                        end
                    end else begin
                        cur_d.data = (bus_rdata & ~step.clr) | step.set;
                        cur_d.ph   = PH_WR;
                    end
                end
            end
            PH_WR: begin
                if (bus_ready) begin
                    cur_d.pc = cur_q.pc + 1'b1;
                    cur_d.ph = PH_EXEC;
                end
            end
            PH_WAIT: begin
                if (t_done) begin
                    cur_d.pc = cur_q.pc + 1'b1;
                    cur_d.ph = PH_EXEC;
                end
            end
            PH_SLEEP: begin
                if (wake) begin
                    cur_d.pc = cur_q.pc + 1'b1;
                    cur_d.ph = PH_EXEC;
                end
            end
            default: cur_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.ph   <= PH_IDLE;
            cur_q.pc   <= '0;
            cur_q.data <= '0;
            cur_q.done <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign busy      = (cur_q.ph != PH_IDLE);
    assign done      = cur_q.done;
    assign bus_valid = (cur_q.ph == PH_RD) || (cur_q.ph == PH_WR);
    assign bus_write = (cur_q.ph == PH_WR);
    assign bus_addr  = step_addr;
    assign bus_wdata = cur_q.data;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] SLEEP_ADDR = 'h4000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wake,
    input logic              busy,
    input logic              done,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ready
);
    logic asleep_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            asleep_q <= 1'b0;
        else if (wake)
            asleep_q <= 1'b0;
        else if (bus_valid && bus_write && bus_ready &&
                 bus_addr == SLEEP_ADDR && bus_wdata[31])
            asleep_q <= 1'b1;
    end

    AST_BUS_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write))); // R2

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !$past(bus_valid && bus_write)) |->
        ($past(bus_valid && !bus_write && bus_ready) && bus_addr == $past(bus_addr))); // R2

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_q |-> (!bus_valid && busy)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R11
endmodule

bind sleep_seq sleep_seq_chk #(.ADDR_W(ADDR_W), .SLEEP_ADDR(SLEEP_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wake      (wake),
    .busy      (busy),
    .done      (done),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
);

// File: tb/sleep_seq_test.sv
module sleep_seq_test;
    localparam int          T_PHY   = 4096;
    localparam int          MHZ     = 25;
    localparam int          BYP_US  = 4;
    localparam int          RST_US  = 1;
    localparam int          LCK_US  = 80;
    localparam logic [31:0] DDR_B   = 32'h1000;
    localparam logic [31:0] PSC_B   = 32'h2000;
    localparam logic [31:0] PLL_B   = 32'h3000;
    localparam logic [31:0] SLP_A   = 32'h4000;
    localparam int          MODN    = 6;

    localparam logic [31:0] A_REF  = DDR_B + 32'h0C;
    localparam logic [31:0] A_MCTL = PSC_B + 32'hA00 + 4 * MODN;
    localparam logic [31:0] A_MST  = PSC_B + 32'h800 + 4 * MODN;
    localparam logic [31:0] A_GO   = PSC_B + 32'h120;
    localparam logic [31:0] A_BSY  = PSC_B + 32'h128;
    localparam logic [31:0] A_PLLC = PLL_B + 32'h100;
    localparam logic [31:0] A_DIV1 = PLL_B + 32'h118;

    logic        clk = 1'b0;
    logic        rst_n, start, wake;
    logic        busy, done, bus_valid, bus_write, bus_ready;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    sleep_seq #(
        .ADDR_W(32), .DDR_BASE(DDR_B), .PSC_BASE(PSC_B), .PLL_BASE(PLL_B),
        .SLEEP_ADDR(SLP_A), .MOD_IDX(MODN), .PHY_WAIT(T_PHY), .CLK_MHZ(MHZ),
        .BYPASS_US(BYP_US), .RESET_US(RST_US), .LOCK_US(LCK_US)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wake(wake),
        .busy(busy), .done(done), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [31:0] addr;
        logic [31:0] clr;
        logic [31:0] set;
        int          gap;
        int          need;
        string       req;
    } entry_t;

    entry_t      exp_q[$];
    logic [31:0] bank [8];
    int          total = 0, bad = 0;
    int          cyc = 0, idle = 0, psc_cnt = 0;
    int          pending_busy = -1, done_at = -1;
    bit          exp_busy = 0, exp_done = 0, head_started = 0;
    bit          stall = 0, wake_sent = 0, finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int idx(logic [31:0] a);
        case (a)
            A_REF:  return 0;
            A_MCTL: return 1;
            A_GO:   return 2;
            A_BSY:  return 3;
            A_MST:  return 4;
            A_DIV1: return 5;
            A_PLLC: return 6;
            SLP_A:  return 7;
            default: return -1;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic add(logic [31:0] a, logic [31:0] c, logic [31:0] s, int g, int n, string r);
        entry_t e;
        e.addr = a; e.clr = c; e.set = s; e.gap = g; e.need = n; e.req = r;
        exp_q.push_back(e);
    endtask

    // expected write program, built from the requirements
    task automatic load_program();
        add(A_REF,  32'h0080_0000, 32'h8000_0000, 0, -1, "R3");
        add(A_REF,  32'h0,         32'h4000_0000, 0, -1, "R3");
        add(A_MCTL, 32'h3F,        32'h2,  T_PHY + 2, -1, "R4");
        add(A_GO,   32'h0,         32'h1,  0, -1, "R5");
        add(A_DIV1, 32'h8000,      32'h0,  0, 2, "R5");
        add(A_PLLC, 32'h21,        32'h0,  0, -1, "R6");
        add(A_PLLC, 32'h0,         32'h2,  BYP_US * MHZ + 2, -1, "R7");
        add(SLP_A,  32'h0,         32'h8000_0000, 0, -1, "R8");
        add(SLP_A,  32'h8000_0000, 32'h0,  0, -1, "R9");
        add(A_PLLC, 32'h8,         32'h0,  0, -1, "R9");
        add(A_PLLC, 32'h2,         32'h0,  0, -1, "R9");
        add(A_PLLC, 32'h0,         32'h8,  RST_US * MHZ + 2, -1, "R9");
        add(A_PLLC, 32'h20,        32'h1,  LCK_US * MHZ + 2, -1, "R12");
        add(A_DIV1, 32'h0,         32'h8000, 0, -1, "R10");
        add(A_MCTL, 32'h3F,        32'h3,  0, -1, "R10");
        add(A_GO,   32'h0,         32'h1,  0, -1, "R5");
        add(A_REF,  32'h4000_0000, 32'h0,  0, 3, "R5");
        add(A_REF,  32'h8000_0000, 32'h0,  0, -1, "R10");
    endtask

    // per-cycle reference model and bus-target model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            int i;
            cyc++;
            if (cyc > 60000) begin
                chk(1'b0, "WDOG", "watchdog expired", 32'(cyc), 32'd60000);
                report();
            end
            if (psc_cnt > 0) begin
                psc_cnt--;
                if (psc_cnt == 0) begin
                    bank[3][0]   = 1'b0;
                    bank[4][5:0] = bank[1][5:0];
                end
            end
            if (cyc == pending_busy) begin
                exp_busy     = 1'b1;
                pending_busy = -1;
            end
            exp_done = (cyc == done_at);
            if (exp_done) exp_busy = 1'b0;
            chk(busy == exp_busy, "R11", "busy", 32'(busy), 32'(exp_busy));
            chk(done == exp_done, "R11", "done", 32'(done), 32'(exp_done));
            if (!exp_busy)
                chk(!bus_valid, "R1", "valid while idle", 32'(bus_valid), 32'd0);
            if (start && !exp_busy && pending_busy < 0)
                pending_busy = cyc + 1;
            if (bank[7][31] && !wake_sent)
                chk(!bus_valid, "R8", "request while asleep", 32'(bus_valid), 32'd0);

            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
            i         = idx(bus_addr);
            bus_rdata = (i >= 0) ? bank[i] : 32'hDEAD_BEEF;

            if (bus_valid) begin
                if (exp_q.size() > 0 && !head_started && !bus_write && bus_addr == exp_q[0].addr) begin
                    head_started = 1'b1;
                    if (exp_q[0].gap > 0)
                        chk(idle == exp_q[0].gap, exp_q[0].req, "idle cycles before access",
                            32'(idle), 32'(exp_q[0].gap));
                end
                idle = 0;
            end else begin
                idle++;
            end

            if (bus_valid && bus_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "access beyond program", bus_addr, 32'h0);
                end else if (bus_write) begin
                    logic [31:0] ev;
                    int hi;
                    hi = idx(exp_q[0].addr);
                    ev = (bank[hi] & ~exp_q[0].clr) | exp_q[0].set;
                    chk(bus_addr == exp_q[0].addr, exp_q[0].req, "write address", bus_addr, exp_q[0].addr);
                    chk(head_started, "R2", "write without read", 32'(head_started), 32'd1);
                    chk(bus_wdata == ev, exp_q[0].req, "write data", bus_wdata, ev);
                    if (i >= 0) bank[i] = bus_wdata;
                    if (i == 2 && bus_wdata[0]) begin
                        bank[2]    = 32'h0;
                        bank[3][0] = 1'b1;
                        psc_cnt    = 4;
                    end
                    void'(exp_q.pop_front());
                    head_started = 1'b0;
                    if (exp_q.size() == 0) done_at = cyc + 2;
                end else if (bus_addr == exp_q[0].addr) begin
                    if (exp_q[0].need >= 0) begin
                        chk(bank[4][5:0] == 6'(exp_q[0].need) && !bank[3][0], "R5",
                            "step before transition complete", {26'd0, bank[4][5:0]}, 32'(exp_q[0].need));
                    end
                end else begin
                    chk(bus_addr == A_BSY || bus_addr == A_MST, "R2", "unexpected read", bus_addr, exp_q[0].addr);
                end
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic pulse_wake(bit real_wake);
        @(posedge clk); #1 wake = 1'b1;
        if (real_wake) wake_sent = 1'b1;
        @(posedge clk); #1 wake = 1'b0;
    endtask

    task automatic run(bit stalls);
        stall     = stalls;
        wake_sent = 1'b0;
        bank[0] = 32'h0080_0123;  bank[1] = 32'h0000_0103;
        bank[2] = 32'h0;          bank[3] = 32'h0;
        bank[4] = 32'h0000_0003;  bank[5] = 32'h0000_8001;
        bank[6] = 32'h0000_0029;  bank[7] = 32'h0000_0055;
        load_program();
        pulse_start();
        repeat (20) @(posedge clk);
        pulse_start();                 // R11: ignored while busy
        if (stalls) pulse_wake(1'b0);  // R8: wake before sleep has no effect
        while (!bank[7][31]) @(posedge clk);
        repeat (60) @(posedge clk);
        chk(busy, "R8", "busy while asleep", 32'(busy), 32'd1);
        chk(exp_q.size() == 10, "R8", "writes pending while asleep", 32'(exp_q.size()), 32'd10);
        pulse_wake(1'b1);
        while (exp_q.size() != 0 || exp_busy || pending_busy >= 0) @(posedge clk);
        repeat (3) @(posedge clk);
        chk(bank[0] == 32'h0000_0123, "R10", "refresh-control final", bank[0], 32'h0000_0123);
        chk(bank[6] == 32'h0000_0009, "R9", "PLL control final", bank[6], 32'h0000_0009);
        chk(bank[5] == 32'h0000_8001, "R10", "divider final", bank[5], 32'h0000_8001);
        chk(bank[1] == 32'h0000_0103, "R10", "module control final", bank[1], 32'h0000_0103);
        chk(bank[7] == 32'h0000_0055, "R9", "sleep register final", bank[7], 32'h0000_0055);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; wake = 1'b0;
        bus_ready = 1'b0; bus_rdata = '0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy, "R1", "busy after reset", 32'(busy), 32'd0);
        chk(!done, "R1", "done after reset", 32'(done), 32'd0);
        chk(!bus_valid, "R1", "valid after reset", 32'(bus_valid), 32'd0);
        run(1'b0);
        run(1'b1);
        finished = 1'b1;
        report();
    end
endmodule